// File: doc/BRIEF.md
# Predicated Logic-Instruction Execute Unit

This block executes one 32-bit instruction per clock against a 512-word, 32-bit register file. It covers three families of single-cycle operations: bitwise combine (and-not, and, or, xor), copy (move, move-inverted) and compare-only (test, test-inverted). Each word carries a 4-bit predicate, a 7-bit opcode, separate write enables for the carry and zero flags, an immediate select, a 9-bit destination address and a 9-bit source field.

Instructions arrive on a valid/ready stream. Ready is normally high. It drops only while the side-band test port writes a register, so a test write and an instruction never share a cycle. A word is consumed on every cycle where valid and ready are both high. There is no stall in the execute path. The test port writes registers and reads them back combinationally, so operands can be preloaded and results checked. An unknown opcode produces a one-cycle illegal pulse.

Top module: `logic_exec_unit`

## Requirements
- R1: Word layout is cond[31:28], opcode[27:21], C-enable[20], Z-enable[19], I[18], dest[17:9], src[8:0]. An accepted legal instruction executes only when cond bit number {C,Z} is 1. So 4'b1111 always runs, 4'b0000 never runs, and 4'b0100 runs only with C=1, Z=0. A squashed instruction changes no register and no flag.
- R2: Opcode 7'b0101001 writes D & S to the destination; opcode 7'b0101000 writes D & ~S.
- R3: Opcode 7'b0101010 writes D | S; opcode 7'b0101011 writes D ^ S.
- R4: Opcode 7'b0110000 writes S; opcode 7'b0110001 writes ~S.
- R5: Opcode 7'b0111111 evaluates D & S and opcode 7'b0111110 evaluates D & ~S. Neither writes the destination register; the result reaches the flags only.
- R6: With I=1 the source operand is src zero-extended to 32 bits. With I=0 it is the register addressed by src.
- R7: When bit 20 is set, carry takes the odd parity of the 32-bit result. When bit 19 is set, zero is set exactly when the result is 0. A flag whose enable is clear keeps its value.
- R8: An accepted word whose opcode is not one of the eight above changes no register or flag. It raises illegal_pulse for exactly the next cycle, whatever its predicate.
- R9: Register and flag updates land on the clock edge that accepts the instruction. An instruction in the very next cycle uses the new values.
- R10: While tp_we is high, in_ready is low and no instruction is consumed. tp_we writes tp_wdata to register tp_addr at the clock edge. tp_rdata shows register tp_addr combinationally.
- R11: After reset both flags are 0, illegal_pulse is 0 and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Unit can take a word this cycle |
| in_word | input | 32 | Instruction word |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| illegal_pulse | output | 1 | One-cycle unknown-opcode indication |
| tp_we | input | 1 | Test port register write |
| tp_addr | input | 9 | Test port register address |
| tp_wdata | input | 32 | Test port write data |
| tp_rdata | output | 32 | Test port read data |

## Verification
The bench issues a dependent instruction in the cycle straight after its producer. A design with late write-back or missing bypass would compute with the stale operand. It evaluates predicates that need exactly one flag combination. A unit that read the cond bits in the wrong order, or only checked always/never, would run or squash the wrong words. It drives instructions that write one flag at a time and test instructions that must leave their destination alone, which exposes enables wired together or a spurious register write. Unknown opcodes, including one under a never-predicate, and an instruction held back by a test write check that nothing leaks through and that the illegal pulse lasts one cycle.

// File: rtl/lxu_pkg.sv
package lxu_pkg;
  localparam int WORD_W = 32;
  localparam int FLD_W  = 9;

  typedef enum logic [6:0] {
    OP_ANDN  = 7'b0101000,
    OP_AND   = 7'b0101001,
    OP_OR    = 7'b0101010,
    OP_XOR   = 7'b0101011,
    OP_MOV   = 7'b0110000,
    OP_NOT   = 7'b0110001,
    OP_TESTN = 7'b0111110,
    OP_TEST  = 7'b0111111
  } opc_e;

  typedef struct packed {
    logic [3:0]       cond;
    logic [6:0]       opc;
    logic             wr_c;
    logic             wr_z;
    logic             imm;
    logic [FLD_W-1:0] dst;
    logic [FLD_W-1:0] src;
  } insn_t;

  function automatic logic opc_known(input logic [6:0] o);
    case (o)
      OP_ANDN, OP_AND, OP_OR, OP_XOR,
      OP_MOV, OP_NOT, OP_TESTN, OP_TEST: opc_known = 1'b1;
      default:                            opc_known = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lxu_regfile.sv
module lxu_regfile #(
  parameter int DW   = 32,
  parameter int AW   = 9,
  parameter int N_RD = 3
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [N_RD-1:0][AW-1:0]  raddr,
  output logic [N_RD-1:0][DW-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/lxu_decode.sv
module lxu_decode
  import lxu_pkg::*;
(
  input  insn_t iw,
  input  logic  cur_c,
  input  logic  cur_z,
  output logic  known,
  output logic  pred_ok,
  output logic  writes_dst
);
  assign known   = opc_known(iw.opc);
  assign pred_ok = iw.cond[{cur_c, cur_z}];

  always_comb begin
    case (iw.opc)
      OP_TESTN, OP_TEST: writes_dst = 1'b0;
      default:           writes_dst = known;
    endcase
  end
endmodule

// File: rtl/lxu_alu.sv
module lxu_alu
  import lxu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [6:0]    opc,
  input  logic [DW-1:0] dval,
  input  logic [DW-1:0] sval,
  output logic [DW-1:0] res,
  output logic          par_odd,
  output logic          is_zero
);
  logic [DW-1:0] s_eff;
  // odd opcode bit 0 selects the plain form for AND/TEST, the inverted form for MOV/NOT
  logic          inv_src;

  always_comb begin
    case (opc)
      OP_ANDN, OP_TESTN, OP_NOT: inv_src = 1'b1;
      default:                   inv_src = 1'b0;
    endcase
  end

  assign s_eff = inv_src ? ~sval : sval;

  always_comb begin
    case (opc)
      OP_ANDN, OP_AND, OP_TESTN, OP_TEST: res = dval & s_eff;
      OP_OR:                              res = dval | sval;
      OP_XOR:                             res = dval ^ sval;
      OP_MOV, OP_NOT:                     res = s_eff;
      default:                            res = '0;
    endcase
  end

  assign par_odd = ^res;
  assign is_zero = (res == '0);
endmodule

// File: rtl/logic_exec_unit.sv
module logic_exec_unit
  import lxu_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int AW = FLD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_word,
  output logic          flag_c,
  output logic          flag_z,
  output logic          illegal_pulse,
  input  logic          tp_we,
  input  logic [AW-1:0] tp_addr,
  input  logic [DW-1:0] tp_wdata,
  output logic [DW-1:0] tp_rdata
);
  localparam int N_RD    = 3;
  localparam int PORT_D  = 0;
  localparam int PORT_S  = 1;
  localparam int PORT_TP = 2;

  insn_t iw;
  logic  accept, known, pred_ok, writes_dst, run;
  logic  par_odd, is_zero;
  logic [DW-1:0] sval, res;
  logic [N_RD-1:0][AW-1:0] raddr;
  logic [N_RD-1:0][DW-1:0] rdata;
  logic          rf_we;
  logic [AW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata;

  assign iw       = insn_t'(in_word);
  assign in_ready = ~tp_we;
  assign accept   = in_valid & in_ready;

  lxu_decode u_dec (
    .iw         (iw),
    .cur_c      (flag_c),
    .cur_z      (flag_z),
    .known      (known),
    .pred_ok    (pred_ok),
    .writes_dst (writes_dst)
  );

  assign run = accept & known & pred_ok;

  assign raddr[PORT_D]  = iw.dst;
  assign raddr[PORT_S]  = iw.src;
  assign raddr[PORT_TP] = tp_addr;
  assign tp_rdata       = rdata[PORT_TP];

  assign sval = iw.imm ? {{(DW-AW){1'b0}}, iw.src} : rdata[PORT_S];

  lxu_alu #(.DW(DW)) u_alu (
    .opc     (iw.opc),
    .dval    (rdata[PORT_D]),
    .sval    (sval),
    .res     (res),
    .par_odd (par_odd),
    .is_zero (is_zero)
  );

  assign rf_we    = tp_we | (run & writes_dst);
  assign rf_waddr = tp_we ? tp_addr  : iw.dst;
  assign rf_wdata = tp_we ? tp_wdata : res;

  lxu_regfile #(.DW(DW), .AW(AW), .N_RD(N_RD)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_c        <= 1'b0;
      flag_z        <= 1'b0;
      illegal_pulse <= 1'b0;
    end else begin
      illegal_pulse <= accept & ~known;
      if (run && iw.wr_c) flag_c <= par_odd;
      if (run && iw.wr_z) flag_z <= is_zero;
    end
  end
endmodule

// File: rtl/lxu_checker.sv
module lxu_checker
  import lxu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_word,
  input logic        tp_we,
  input logic        flag_c,
  input logic        flag_z,
  input logic        illegal_pulse
);
  logic took;
  assign took = in_valid && in_ready;

  AST_TP_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    tp_we |-> !in_ready); // R10

  AST_ILLEGAL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_pulse |-> $past(took && !opc_known(in_word[27:21]))); // R8

  AST_ILLEGAL_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !opc_known(in_word[27:21])) |=> ($stable(flag_c) && $stable(flag_z))); // R8

  AST_NEVER_PRED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (took && in_word[31:28] == 4'b0000) |=> ($stable(flag_c) && $stable(flag_z))); // R1

  AST_C_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !in_word[20]) |=> $stable(flag_c)); // R7

  AST_Z_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !in_word[19]) |=> $stable(flag_z)); // R7

  AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !took |=> ($stable(flag_c) && $stable(flag_z) && !illegal_pulse)); // R9
endmodule

bind logic_exec_unit lxu_checker u_lxu_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_word       (in_word),
  .tp_we         (tp_we),
  .flag_c        (flag_c),
  .flag_z        (flag_z),
  .illegal_pulse (illegal_pulse)
);

// File: tb/logic_exec_unit_test.sv
module logic_exec_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        flag_c, flag_z, illegal_pulse;
  logic        tp_we = 1'b0;
  logic [8:0]  tp_addr = '0;
  logic [31:0] tp_wdata = '0;
  logic [31:0] tp_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit live = 0;

  logic [31:0] mreg [512];
  logic mc = 0, mz = 0, mill = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .flag_c(flag_c), .flag_z(flag_z),
    .illegal_pulse(illegal_pulse), .tp_we(tp_we), .tp_addr(tp_addr),
    .tp_wdata(tp_wdata), .tp_rdata(tp_rdata)
  );

  function automatic logic [31:0] enc(input logic [3:0] cnd, input logic [6:0] op,
                                      input logic c, input logic z, input logic i,
                                      input logic [8:0] d, input logic [8:0] s);
    return {cnd, op, c, z, i, d, s};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model, stepped on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mc = 0; mz = 0; mill = 0;
    end else begin
      logic [31:0] sv, r;
      logic wr, known;
      mill = 0;
      if (tp_we) mreg[tp_addr] = tp_wdata;
      else if (in_valid) begin
        known = 1; wr = 1; r = '0;
        sv = in_word[18] ? {23'd0, in_word[8:0]} : mreg[in_word[8:0]];
        case (in_word[27:21])
          7'b0101000: r = mreg[in_word[17:9]] & ~sv;
          7'b0101001: r = mreg[in_word[17:9]] & sv;
          7'b0101010: r = mreg[in_word[17:9]] | sv;
          7'b0101011: r = mreg[in_word[17:9]] ^ sv;
          7'b0110000: r = sv;
          7'b0110001: r = ~sv;
          7'b0111110: begin r = mreg[in_word[17:9]] & ~sv; wr = 0; end
          7'b0111111: begin r = mreg[in_word[17:9]] & sv;  wr = 0; end
          default:    known = 0;
        endcase
        if (!known) mill = 1;
        else if (in_word[28 + {mc, mz}]) begin
          if (wr) mreg[in_word[17:9]] = r;
          if (in_word[20]) mc = ^r;
          if (in_word[19]) mz = (r == 0);
        end
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (live) begin
      chk("R7 flag_c vs model", {31'd0, flag_c}, {31'd0, mc});
      chk("R7 flag_z vs model", {31'd0, flag_z}, {31'd0, mz});
      chk("R8 illegal_pulse vs model", {31'd0, illegal_pulse}, {31'd0, mill});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic issue(input logic [31:0] w);
    @(negedge clk); in_valid = 1; in_word = w;
  endtask
  task automatic idle();
    @(negedge clk); in_valid = 0; in_word = '0;
  endtask
  task automatic exec(input logic [31:0] w);
    issue(w); idle();
  endtask
  task automatic wr_reg(input logic [8:0] a, input logic [31:0] v);
    @(negedge clk); tp_we = 1; tp_addr = a; tp_wdata = v;
    #1 chk("R10 ready low during test write", {31'd0, in_ready}, 32'd0);
    @(negedge clk); tp_we = 0;
  endtask
  task automatic rd_reg(input string tag, input logic [8:0] a, input logic [31:0] exp);
    @(negedge clk); tp_addr = a;
    #1 chk(tag, tp_rdata, exp);
  endtask
  task automatic flags(input string tag, input logic c, input logic z);
    chk(tag, {30'd0, flag_c, flag_z}, {30'd0, c, z});
  endtask

  localparam logic [3:0] AL = 4'hF;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R11 reset flags", {30'd0, flag_c, flag_z}, 32'd0);
    chk("R11 reset illegal", {31'd0, illegal_pulse}, 32'd0);
    chk("R11 reset ready", {31'd0, in_ready}, 32'd1);
    live = 1;

    wr_reg(1, 32'hF0F0_1234); wr_reg(2, 32'h0FF0_00FF); wr_reg(3, 32'h0);
    wr_reg(4, 32'hFFFF_FFFF); wr_reg(5, 32'hFFFF_0000); wr_reg(21, 32'h0);
    rd_reg("R10 readback", 1, 32'hF0F0_1234);

    // R2
    exec(enc(AL, 7'b0101001, 1, 1, 0, 1, 2));
    flags("R7 AND parity odd, nonzero", 1, 0);
    rd_reg("R2 AND result", 1, 32'h00F0_0034);
    exec(enc(AL, 7'b0101000, 0, 1, 1, 5, 9'h1FF));
    rd_reg("R2 ANDN result", 5, 32'hFFFF_0000);

    // R3
    exec(enc(AL, 7'b0101010, 0, 0, 0, 3, 2));
    rd_reg("R3 OR result", 3, 32'h0FF0_00FF);
    exec(enc(AL, 7'b0101011, 1, 1, 1, 3, 9'h0FF));
    flags("R7 XOR parity even", 0, 0);
    rd_reg("R3 XOR result", 3, 32'h0FF0_0000);

    // R4
    exec(enc(AL, 7'b0110000, 0, 0, 1, 6, 9'h155));
    rd_reg("R4 MOV imm", 6, 32'h155);
    exec(enc(AL, 7'b0110001, 0, 1, 0, 7, 4));
    chk("R7 zero flag set", {31'd0, flag_z}, 32'd1);
    rd_reg("R4 NOT result", 7, 32'h0);

    // R5
    exec(enc(AL, 7'b0111111, 1, 1, 0, 4, 3));
    flags("R5 TEST flags", 0, 0);
    rd_reg("R5 TEST leaves dest", 4, 32'hFFFF_FFFF);
    exec(enc(AL, 7'b0111110, 0, 1, 0, 4, 4));
    flags("R5 TESTN zero", 0, 1);
    rd_reg("R5 TESTN leaves dest", 4, 32'hFFFF_FFFF);

    // R1 predicates
    exec(enc(4'b0000, 7'b0110000, 1, 1, 1, 6, 0));
    flags("R1 never keeps flags", 0, 1);
    rd_reg("R1 never keeps dest", 6, 32'h155);
    exec(enc(AL, 7'b0110000, 1, 1, 1, 8, 1));
    flags("R7 C=1 Z=0", 1, 0);
    exec(enc(4'b0100, 7'b0110000, 0, 0, 1, 9, 7));
    rd_reg("R1 cond bit2 runs", 9, 32'h7);
    exec(enc(4'b1011, 7'b0110000, 0, 0, 1, 9, 3));
    rd_reg("R1 cond bit2 clear squashes", 9, 32'h7);

    // R7 separate enables
    exec(enc(AL, 7'b0110000, 1, 0, 1, 10, 1));
    flags("R7 C only", 1, 0);
    exec(enc(AL, 7'b0110000, 0, 1, 1, 10, 0));
    flags("R7 Z only", 1, 1);

    // R8 illegal
    exec(enc(AL, 7'b1111111, 1, 1, 1, 9, 0));
    chk("R8 pulse high", {31'd0, illegal_pulse}, 32'd1);
    flags("R8 flags kept", 1, 1);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'd0, illegal_pulse}, 32'd0);
    rd_reg("R8 dest kept", 9, 32'h7);
    exec(enc(4'b0000, 7'b0000000, 0, 0, 1, 9, 0));
    chk("R8 pulse under never predicate", {31'd0, illegal_pulse}, 32'd1);

    // R9 back-to-back dependency
    issue(enc(AL, 7'b0110000, 0, 0, 1, 11, 9'h0AA));
    issue(enc(AL, 7'b0101011, 0, 0, 1, 11, 9'h0FF));
    idle();
    rd_reg("R9 forwarded result", 11, 32'h055);

    // R6 register vs immediate source
    exec(enc(AL, 7'b0110000, 0, 0, 0, 12, 6));
    rd_reg("R6 register source", 12, 32'h155);
    exec(enc(AL, 7'b0110000, 0, 0, 1, 13, 6));
    rd_reg("R6 immediate source", 13, 32'h6);

    // R10 back-pressure
    @(negedge clk);
    tp_we = 1; tp_addr = 20; tp_wdata = 32'hCAFE_0001;
    in_valid = 1; in_word = enc(AL, 7'b0110000, 0, 0, 1, 21, 9'h011);
    #1 chk("R10 ready low", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    tp_we = 0; tp_addr = 21;
    #1 chk("R10 held instruction not consumed", tp_rdata, 32'h0);
    idle();
    rd_reg("R10 instruction after release", 21, 32'h011);
    rd_reg("R10 test write landed", 20, 32'hCAFE_0001);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule